// File: doc/BRIEF.md
# Multi-region register window decoder

This block is a 64 KiB register window behind a single request/acknowledge bus port. It holds three sub-regions. The first is a configuration array of 32-bit registers based at byte offset 0x60. The second is a separate power-management array based at 0x200. The third is a one-word read-only identification view at 0x800. Both arrays space their registers 16 bytes apart. Within each 16-byte slot, address bits [3:2] choose the update applied by a write: plain write, bit set, bit clear or bit toggle. Reads return the register value for any of the four codes.

The identification word is stored in one register of the configuration array. That register can be written through the array. Through the 0x800 view it is only readable, and it wins over any array that overlaps that word. Where the two arrays overlap, the power array wins over the configuration array. Reset loads a fixed image. Four clock-control registers come up non-zero with their lock status bit already set. The identification register comes up with a family code and a revision code. Everything else resets to zero.

Each access goes through a three-state controller. IDLE accepts a request (transition ACCEPT) and moves to EXEC. EXEC decodes the captured address, applies the write or samples the read data (transition EXECUTE) and moves to RESP. RESP drives acknowledge for one cycle and returns to IDLE (transition RESPOND).

Top module: `regwin_top`

## Requirements
- R1: After reset, configuration registers 0, 1, 2 and 3 read 0x00002042, 0x0060302c, 0x00001fc0 and 0x0001301b, each ORed with the lock bit (bit LOCK_BIT, default 31). The identification register reads 0x00720010. All other registers of both arrays read zero. After reset, ack and rdata are 0.
- R2: A write with address bits [3:2] = 0 (offset nibble 0x0) replaces the addressed register with wdata.
- R3: A write with nibble 0x4 ORs wdata into the addressed register.
- R4: A write with nibble 0x8 clears the bits that are set in wdata.
- R5: A write with nibble 0xC inverts the bits that are set in wdata.
- R6: The word at 0x800–0x803 reads the identification register, which is configuration register IDENT_REG (offset 0x60 + 16*IDENT_REG). This view takes priority over any overlapping array, and writes through it are dropped. Writes through the array offset change the value that 0x800 returns.
- R7: Addresses inside the power array (0x200 + 16*k) reach power register k. Where both arrays cover an address, the power array takes priority over the configuration array.
- R8: An address in no region reads as zero and raises no error. A write to it changes no register.
- R9: A request with addr[1:0] != 0 responds with err = 1 and rdata = 0, and changes no register.
- R10: A request is accepted only in IDLE. Acknowledge is high for exactly one cycle, two clock edges after the accepting edge. A request raised while busy is ignored.
- R11: A read returns the addressed register's value whatever the update code in bits [3:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the reset image |
| req | input | 1 | Access request, sampled in IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset within the window |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle response strobe |
| err | output | 1 | Misaligned access flag, valid with ack |
| rdata | output | 32 | Read data, valid with ack |

## Verification
The bench builds the block with a 512-word configuration array, a 64-word power array, IDENT_REG = 15 and the lock bit at 31. With these values the configuration array spans 0x60–0x85F and overlaps both the power array and the 0x800 identification word. That brings both priority rules within reach. It also shows that 0x804 still reaches configuration register 122 while 0x800 does not. The default sizes leave all three regions disjoint, so they exercise neither priority path.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } sct_op_e;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_IDENT = 2'd1,
        RG_PWR   = 2'd2,
        RG_ARR   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_RESP = 2'd2
    } fsm_e;

    localparam logic [31:0] FAMILY_CODE   = 32'h0072_0000;
    localparam logic [31:0] REVISION_CODE = 32'h0000_0010;

    // Reset image: identification word, four clock-control words with lock bit, rest zero
    function automatic logic [31:0] reset_word(input bit is_pwr, input int idx,
                                               input int lock_bit, input int ident_reg);
        logic [31:0] lock;
        logic [31:0] val;
        lock = 32'd1 << lock_bit;
        val  = '0;
        if (!is_pwr) begin
            if (idx == ident_reg) begin
                val = FAMILY_CODE | REVISION_CODE;
            end else begin
                case (idx)
                    0:       val = 32'h0000_2042 | lock;
                    1:       val = 32'h0060_302c | lock;
                    2:       val = 32'h0000_1fc0 | lock;
                    3:       val = 32'h0001_301b | lock;
                    default: val = '0;
                endcase
            end
        end
        return val;
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ARR_BASE   = 32'h60,
    parameter int ARR_WORDS  = 64,
    parameter int PWR_BASE   = 32'h200,
    parameter int PWR_WORDS  = 64,
    parameter int IDENT_ADDR = 32'h800,
    parameter int ARR_IW     = 4,
    parameter int PWR_IW     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ARR_IW-1:0] arr_idx,
    output logic [PWR_IW-1:0] pwr_idx,
    output sct_op_e           op,
    output logic              misaligned
);
    localparam logic [31:0] ARR_LO = 32'(ARR_BASE);
    localparam logic [31:0] ARR_HI = 32'(ARR_BASE + ARR_WORDS * 4);
    localparam logic [31:0] PWR_LO = 32'(PWR_BASE);
    localparam logic [31:0] PWR_HI = 32'(PWR_BASE + PWR_WORDS * 4);

    logic [31:0]       addr_w;
    logic [ADDR_W-1:0] arr_off;
    logic [ADDR_W-1:0] pwr_off;
    logic              hit_ident;
    logic              hit_pwr;
    logic              hit_arr;

    always_comb begin
        addr_w     = 32'(addr);
        arr_off    = addr - ADDR_W'(ARR_BASE);
        pwr_off    = addr - ADDR_W'(PWR_BASE);
        arr_idx    = ARR_IW'(arr_off >> 4);
        pwr_idx    = PWR_IW'(pwr_off >> 4);
        op         = sct_op_e'(addr[3:2]);
        misaligned = (addr[1:0] != 2'b00);
        hit_ident  = (addr[ADDR_W-1:2] == (ADDR_W-2)'(IDENT_ADDR >> 2));
        hit_pwr    = (addr_w >= PWR_LO) && (addr_w < PWR_HI);
        hit_arr    = (addr_w >= ARR_LO) && (addr_w < ARR_HI);
        // highest priority first
        if (hit_ident)    region = RG_IDENT;
        else if (hit_pwr) region = RG_PWR;
        else if (hit_arr) region = RG_ARR;
        else              region = RG_NONE;
    end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
    import regwin_pkg::*;
#(
    parameter int NREGS     = 16,   // power of two
    parameter int IW        = 4,
    parameter bit IS_PWR    = 1'b0,
    parameter int LOCK_BIT  = 31,
    parameter int IDENT_REG = 15,
    parameter int TAP_REG   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  sct_op_e       op,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output logic [31:0]   tap_data
);
    logic [31:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= reset_word(IS_PWR, i, LOCK_BIT, IDENT_REG);
            end
        end else if (wr_en) begin
            unique case (op)
                OP_WRITE:  regs[wr_idx] <= wdata;
                OP_SET:    regs[wr_idx] <= regs[wr_idx] | wdata;
                OP_CLEAR:  regs[wr_idx] <= regs[wr_idx] & ~wdata;
                OP_TOGGLE: regs[wr_idx] <= regs[wr_idx] ^ wdata;
                default:   regs[wr_idx] <= regs[wr_idx];
            endcase
        end
    end

    assign rd_data  = regs[rd_idx];
    assign tap_data = regs[TAP_REG];

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=> ((regs[$past(wr_idx)] & $past(wdata)) == $past(wdata)));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLEAR) |=> ((regs[$past(wr_idx)] & $past(wdata)) == 32'd0));
endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ARR_BASE   = 32'h60,
    parameter int ARR_WORDS  = 64,
    parameter int PWR_BASE   = 32'h200,
    parameter int PWR_WORDS  = 64,
    parameter int IDENT_ADDR = 32'h800,
    parameter int IDENT_REG  = 15,
    parameter int LOCK_BIT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              ack,
    output logic              err,
    output logic [31:0]       rdata
);
    localparam int ARR_REGS = ARR_WORDS / 4;
    localparam int PWR_REGS = PWR_WORDS / 4;
    localparam int ARR_IW   = $clog2(ARR_REGS);
    localparam int PWR_IW   = $clog2(PWR_REGS);

    fsm_e              state, state_nx;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic [31:0]       rdata_q;
    logic              err_q;

    region_e           region;
    sct_op_e           op;
    logic              misaligned;
    logic [ARR_IW-1:0] arr_idx;
    logic [PWR_IW-1:0] pwr_idx;
    logic [31:0]       arr_rd, arr_tap, pwr_rd, pwr_tap;
    logic              arr_wr, pwr_wr;
    logic [31:0]       rd_mux;

    regwin_decode #(
        .ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_WORDS(ARR_WORDS),
        .PWR_BASE(PWR_BASE), .PWR_WORDS(PWR_WORDS), .IDENT_ADDR(IDENT_ADDR),
        .ARR_IW(ARR_IW), .PWR_IW(PWR_IW)
    ) u_decode (
        .addr(addr_q), .region(region), .arr_idx(arr_idx), .pwr_idx(pwr_idx),
        .op(op), .misaligned(misaligned)
    );

    regwin_bank #(
        .NREGS(ARR_REGS), .IW(ARR_IW), .IS_PWR(1'b0), .LOCK_BIT(LOCK_BIT),
        .IDENT_REG(IDENT_REG), .TAP_REG(IDENT_REG)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(arr_wr), .op(op), .wr_idx(arr_idx),
        .wdata(wdata_q), .rd_idx(arr_idx), .rd_data(arr_rd), .tap_data(arr_tap)
    );

    regwin_bank #(
        .NREGS(PWR_REGS), .IW(PWR_IW), .IS_PWR(1'b1), .LOCK_BIT(LOCK_BIT),
        .IDENT_REG(IDENT_REG), .TAP_REG(0)
    ) u_pwr (
        .clk(clk), .rst_n(rst_n), .wr_en(pwr_wr), .op(op), .wr_idx(pwr_idx),
        .wdata(wdata_q), .rd_idx(pwr_idx), .rd_data(pwr_rd), .tap_data(pwr_tap)
    );

    // next-state logic: ACCEPT, EXECUTE, RESPOND
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req) state_nx = S_EXEC;
            S_EXEC:  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state == S_IDLE && req) begin
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state == S_EXEC) begin
                err_q   <= misaligned;
                rdata_q <= (!we_q && !misaligned) ? rd_mux : 32'd0;
            end
        end
    end

    always_comb begin
        unique case (region)
            RG_IDENT: rd_mux = arr_tap;
            RG_PWR:   rd_mux = pwr_rd;
            RG_ARR:   rd_mux = arr_rd;
            default:  rd_mux = 32'd0;
        endcase
        arr_wr = (state == S_EXEC) && we_q && !misaligned && (region == RG_ARR);
        pwr_wr = (state == S_EXEC) && we_q && !misaligned && (region == RG_PWR);
    end

    // outputs
    always_comb begin
        ack   = (state == S_RESP);
        err   = err_q;
        rdata = rdata_q;
    end

    assert_ack_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req) |=> (!ack ##1 ack));

    assert_ident_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && we_q && region == RG_IDENT) |=> $stable(arr_tap));

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && err) |-> (rdata == 32'd0));

    assert_pwr_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && region != RG_PWR) |=> $stable(pwr_tap));
endmodule

// File: tb/test_regwin_top.sv
module test_regwin_top;
    localparam int AW     = 16;
    localparam int A_BASE = 32'h60;
    localparam int A_WRD  = 512;
    localparam int P_BASE = 32'h200;
    localparam int P_WRD  = 64;
    localparam int ID_REG = 15;
    localparam int LOCKB  = 31;
    localparam int A_N    = A_WRD / 4;
    localparam int P_N    = P_WRD / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          ack, err;
    logic [31:0]   rdata;

    int total = 0;
    int bad = 0;
    logic [31:0] m_a [A_N];
    logic [31:0] m_p [P_N];

    always #5 clk = ~clk;

    regwin_top #(
        .ADDR_W(AW), .ARR_BASE(A_BASE), .ARR_WORDS(A_WRD), .PWR_BASE(P_BASE),
        .PWR_WORDS(P_WRD), .IDENT_ADDR(32'h800), .IDENT_REG(ID_REG), .LOCK_BIT(LOCKB)
    ) i_regwin_top (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .err(err), .rdata(rdata)
    );

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // 0 none, 1 ident, 2 power, 3 config array
    function automatic int region_of(input logic [AW-1:0] a);
        int ai = int'(a);
        if (a[AW-1:2] == 14'h200) return 1;
        if (ai >= P_BASE && ai < P_BASE + P_WRD * 4) return 2;
        if (ai >= A_BASE && ai < A_BASE + A_WRD * 4) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        case (region_of(a))
            1:       return m_a[ID_REG];
            2:       return m_p[(int'(a) - P_BASE) / 16];
            3:       return m_a[(int'(a) - A_BASE) / 16];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] apply_op(input logic [31:0] old, input logic [1:0] code,
                                             input logic [31:0] d);
        case (code)
            2'd0:    return d;
            2'd1:    return old | d;
            2'd2:    return old & ~d;
            default: return old ^ d;
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int k;
        if (a[1:0] != 2'b00) return;
        case (region_of(a))
            2: begin k = (int'(a) - P_BASE) / 16; m_p[k] = apply_op(m_p[k], a[3:2], d); end
            3: begin k = (int'(a) - A_BASE) / 16; m_a[k] = apply_op(m_a[k], a[3:2], d); end
            default: ;
        endcase
    endtask

    task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        check("R10 ack low one cycle after accept", 32'(ack), 32'd0);
        @(negedge clk);
        check("R10 ack high two edges after accept", 32'(ack), 32'd1);
        rd = rdata;
        e  = err;
        @(negedge clk);
        check("R10 ack lasts one cycle", 32'(ack), 32'd0);
    endtask

    task automatic rd_chk(input string r, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        logic e;
        access(1'b0, a, 32'd0, v, e);
        check(r, v, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] v;
        logic e;
        access(1'b1, a, d, v, e);
        model_write(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic e;
        logic [AW-1:0] a;
        logic [31:0] d;
        logic w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < A_N; i++) m_a[i] = 32'd0;
        for (int i = 0; i < P_N; i++) m_p[i] = 32'd0;
        m_a[0] = 32'h8000_2042;
        m_a[1] = 32'h8060_302c;
        m_a[2] = 32'h8000_1fc0;
        m_a[3] = 32'h8001_301b;
        m_a[ID_REG] = 32'h0072_0010;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", 32'(ack), 32'd0);
        check("R1 rdata after reset", rdata, 32'd0);

        // R1 reset image
        rd_chk("R1 cfg0", 16'h0060, 32'h8000_2042);
        rd_chk("R1 cfg1", 16'h0070, 32'h8060_302c);
        rd_chk("R1 cfg2", 16'h0080, 32'h8000_1fc0);
        rd_chk("R1 cfg3", 16'h0090, 32'h8001_301b);
        rd_chk("R1 cfg4 zero", 16'h00a0, 32'd0);
        rd_chk("R1 ident", 16'h0800, 32'h0072_0010);
        rd_chk("R1 ident alias", 16'h0150, 32'h0072_0010);
        rd_chk("R1 pwr0 zero", 16'h0200, 32'd0);

        // R2..R5, R11 on config register 5 (0xB0)
        wr(16'h00b0, 32'h1234_5678);
        rd_chk("R2 plain write", 16'h00b0, 32'h1234_5678);
        rd_chk("R11 read via set code", 16'h00b4, 32'h1234_5678);
        rd_chk("R11 read via toggle code", 16'h00bc, 32'h1234_5678);
        wr(16'h00b4, 32'h0000_00f0);
        rd_chk("R3 set", 16'h00b0, 32'h1234_56f8);
        wr(16'h00b8, 32'h1200_0008);
        rd_chk("R4 clear", 16'h00b0, 32'h0034_56f0);
        wr(16'h00bc, 32'hffff_0000);
        rd_chk("R5 toggle", 16'h00b0, 32'hffcb_56f0);

        // R6 identification view
        wr(16'h0800, 32'hdead_beef);
        rd_chk("R6 ident write dropped", 16'h0800, 32'h0072_0010);
        rd_chk("R6 alias unchanged", 16'h0150, 32'h0072_0010);
        wr(16'h0150, 32'habcd_0001);
        rd_chk("R6 alias write visible at ident", 16'h0800, 32'habcd_0001);
        wr(16'h0804, 32'h0000_0001);
        rd_chk("R6 ident wins over cfg122", 16'h0800, 32'habcd_0001);
        rd_chk("R6 cfg122 via other code", 16'h0808, 32'h0000_0001);

        // R7 power array priority
        wr(16'h0200, 32'h0000_0055);
        rd_chk("R7 pwr0 write", 16'h0200, 32'h0000_0055);
        wr(16'h02f4, 32'h8000_0000);
        rd_chk("R7 pwr15 set", 16'h02f0, 32'h8000_0000);
        rd_chk("R7 cfg next to pwr untouched", 16'h0300, 32'd0);

        // R8 unmapped
        wr(16'h0010, 32'hffff_ffff);
        rd_chk("R8 unmapped low reads zero", 16'h0010, 32'd0);
        wr(16'h9000, 32'hffff_ffff);
        rd_chk("R8 unmapped high reads zero", 16'h9000, 32'd0);
        rd_chk("R8 pwr0 unchanged", 16'h0200, 32'h0000_0055);

        // R9 misaligned
        access(1'b1, 16'h00b2, 32'h0, v, e);
        check("R9 misaligned write err", 32'(e), 32'd1);
        access(1'b0, 16'h00b1, 32'h0, v, e);
        check("R9 misaligned read err", 32'(e), 32'd1);
        check("R9 misaligned read data", v, 32'd0);
        rd_chk("R9 no write on misaligned", 16'h00b0, 32'hffcb_56f0);

        // R10 request while busy ignored
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 16'h00b0;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h00b0; wdata = 32'h0;
        @(negedge clk);
        req = 1'b0;
        check("R10 ack for first request", 32'(ack), 32'd1);
        check("R10 first read data", rdata, 32'hffcb_56f0);
        @(negedge clk);
        @(negedge clk);
        check("R10 no ack for busy request", 32'(ack), 32'd0);
        rd_chk("R10 busy write ignored", 16'h00b0, 32'hffcb_56f0);

        // random mix against the model
        for (int n = 0; n < 400; n++) begin
            int kind;
            kind = $urandom_range(0, 5);
            w = 1'($urandom_range(0, 1));
            d = $urandom;
            case (kind)
                0: a = 16'(A_BASE + 16 * $urandom_range(0, A_N - 1) + 4 * $urandom_range(0, 3));
                1: a = 16'(P_BASE + 16 * $urandom_range(0, P_N - 1) + 4 * $urandom_range(0, 3));
                2: a = 16'h0800;
                3: a = ($urandom_range(0, 1) == 0) ? 16'(4 * $urandom_range(0, 23))
                                                   : 16'(4 * $urandom_range(16'h0218, 16'h3fff));
                4: a = 16'(A_BASE + 16 * $urandom_range(0, A_N - 1) + $urandom_range(1, 3));
                default: a = 16'(A_BASE + 16 * ID_REG + 4 * $urandom_range(0, 3));
            endcase
            access(w, a, d, v, e);
            check("R9 err flag", 32'(e), 32'(a[1:0] != 2'b00));
            if (w) model_write(a, d);
            else   check("R2 R7 R8 R11 random read", v, model_read(a));
        end
        rd_chk("R6 final ident view", 16'h0800, m_a[ID_REG]);
        rd_chk("R7 final pwr0", 16'h0200, m_p[0]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule